// File: doc/BRIEF.md
# Banked Control Register File with Write Protection

This block holds the system control registers of a multithreaded processor core. Each register sits at a flat 8-bit index. The upper five bits of the index give the register number and the lower three bits give the select. Every register belongs to one of three bank classes. A shared register has one copy for the whole core. A per-VPE register has one copy for each virtual processing element. A per-thread register has one copy for each hardware thread context.

All three ports carry a requesting thread ID:

- **Read port.** Combinational.
- **Software write port.** Passes each stored bit through that register's fixed write mask.
- **Direct write port.** Used for hardware updates and setup. It stores the full word.

For per-thread registers, the requesting thread picks the copy. For per-VPE registers, the copy is picked by the VPE number held in the requesting thread's binding register. Reset loads fixed defaults, including each thread's own index in its binding register.

A one-cycle pulse follows every software write that lands on an implemented register. Downstream logic uses it to re-evaluate thread run state.

Top module: `ctl_regbank`

## Requirements
- R1: Index map (hex index, class, reset value, write mask):
  - Shared registers:
    - TLBIDX 00: reset 0, mask 7FFFFFFF
    - RNDM 08: reset 0x3F, mask 0
    - ELO0 10 and ELO1 18: reset 0, mask 3FFFFFFF
    - CTXT 20: reset 0, mask FF800000
    - PGMSK 28: reset 0, mask 1FFFF800
    - BADVA 40: reset 0, mask 0
    - INTC 61: reset 0, mask 000003E0
    - SRSC 62: reset 0, mask 0000F3C0
    - CAUSE 68: reset 0, mask 08C00300
    - PRID 78: reset PRID_VAL, mask 0
    - CFG0 80: reset CFG_VAL, mask 7FFF0007
  - Per-VPE registers:
    - VCTL 09: reset 0, mask FFFFFFFF
    - EXBASE 79: reset 0x80000000 OR the VPE number, mask 3FFFF000
  - Per-thread registers:
    - STAT 60: mask FF78FF17
    - TSTAT 11: mask FFFFFFFF
    - TBIND 12: mask FFFFFFFF
    - THALT 14: mask FFFFFFFF
    - LLADR 88: mask 0
- R2: An index outside the R1 map reads as 0 with `rd_hit` low, and writes to it change nothing.
- R3: A software write stores `(wr_data & mask) | (old & ~mask)` into the addressed copy.
- R4: A direct write stores `dw_data` unmasked. When both write ports address the same copy in one cycle, the direct write wins.
- R5: Per-thread registers are indexed by the port's thread ID, and a write to one thread's copy leaves the other threads' copies unchanged.
- R6: A per-VPE access uses the copy numbered by the low log2(NUM_VPE) bits of the requesting thread's TBIND (bit 0 by default). Changing TBIND redirects that thread's later per-VPE accesses.
- R7: After reset, STAT reads 0x00400004 in every thread. TSTAT reads 0x00008000 for thread 0 and 0x00200000 for the others. TBIND reads the thread index shifted left by 21. THALT and LLADR read 0.
- R8: A register whose mask is 0 (RNDM, PRID, BADVA, LLADR) is not changed by software writes.
- R9: `upd_pulse` is high for exactly the one cycle after a clock edge that took a software write to a mapped index, and low otherwise.
- R10: Read data is combinational: a write taken at an edge is visible on `rd_data` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_tid | input | TW | Thread ID for read |
| rd_idx | input | 8 | Read index |
| rd_data | output | 32 | Read data |
| rd_hit | output | 1 | Read index is mapped |
| wr_en | input | 1 | Software (masked) write strobe |
| wr_tid | input | TW | Thread ID for software write |
| wr_idx | input | 8 | Software write index |
| wr_data | input | 32 | Software write data |
| dw_en | input | 1 | Direct write strobe |
| dw_tid | input | TW | Thread ID for direct write |
| dw_idx | input | 8 | Direct write index |
| dw_data | input | 32 | Direct write data |
| upd_pulse | output | 1 | One-cycle pulse after a mapped software write |

## Verification
Read data has no register stage, so the bench samples `rd_data` one time unit after it changes the read address. Both write ports land at a single rising edge. The bench drives a write on the falling edge, lets one rising edge pass, and then samples just after that edge. At that point both the stored value (through the read port) and `upd_pulse` are due. `upd_pulse` is checked again one edge later, when it must have fallen.

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter int NUM_TC  = 4,
  parameter int NUM_VPE = 2,
  parameter logic [31:0] PRID_VAL = 32'h0001_9300,
  parameter logic [31:0] CFG_VAL  = 32'h8000_0482,
  localparam int TW = (NUM_TC  > 1) ? $clog2(NUM_TC)  : 1,
  localparam int VW = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] rd_tid,
  input  logic [7:0]    rd_idx,
  output logic [31:0]   rd_data,
  output logic          rd_hit,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tid,
  input  logic [7:0]    wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          dw_en,
  input  logic [TW-1:0] dw_tid,
  input  logic [7:0]    dw_idx,
  input  logic [31:0]   dw_data,
  output logic          upd_pulse
);

  localparam int NSH = 12;
  localparam int NVR = 2;
  localparam int NTR = 5;
  localparam int SHW = $clog2(NSH);
  localparam int VRW = $clog2(NVR);
  localparam int TRW = $clog2(NTR);

  localparam logic [1:0] C_NONE = 2'd0, C_SH = 2'd1, C_VP = 2'd2, C_TC = 2'd3;

  localparam int S_IDX = 0, S_RND = 1, S_EL0 = 2, S_EL1 = 3, S_CTX = 4, S_PGM = 5;
  localparam int S_BVA = 6, S_CAU = 7, S_PID = 8, S_CFG = 9, S_ICT = 10, S_SRC = 11;
  localparam int V_CTL = 0, V_EB = 1;
  localparam int T_STAT = 0, T_TST = 1, T_BIND = 2, T_HALT = 3, T_LLA = 4;

  localparam logic [31:0] STAT_M = 32'hFF78_FF17;

  function automatic logic [5:0] decode(input logic [7:0] a);
    case (a)
      8'h00: return {C_SH, 4'(S_IDX)};
      8'h08: return {C_SH, 4'(S_RND)};
      8'h10: return {C_SH, 4'(S_EL0)};
      8'h18: return {C_SH, 4'(S_EL1)};
      8'h20: return {C_SH, 4'(S_CTX)};
      8'h28: return {C_SH, 4'(S_PGM)};
      8'h40: return {C_SH, 4'(S_BVA)};
      8'h68: return {C_SH, 4'(S_CAU)};
      8'h78: return {C_SH, 4'(S_PID)};
      8'h80: return {C_SH, 4'(S_CFG)};
      8'h61: return {C_SH, 4'(S_ICT)};
      8'h62: return {C_SH, 4'(S_SRC)};
      8'h09: return {C_VP, 4'(V_CTL)};
      8'h79: return {C_VP, 4'(V_EB)};
      8'h60: return {C_TC, 4'(T_STAT)};
      8'h11: return {C_TC, 4'(T_TST)};
      8'h12: return {C_TC, 4'(T_BIND)};
      8'h14: return {C_TC, 4'(T_HALT)};
      8'h88: return {C_TC, 4'(T_LLA)};
      default: return {C_NONE, 4'd0};
    endcase
  endfunction

  function automatic logic [31:0] sh_mask(input logic [SHW-1:0] s);
    case (s)
      SHW'(S_IDX): return 32'h7FFF_FFFF;
      SHW'(S_EL0), SHW'(S_EL1): return 32'h3FFF_FFFF;
      SHW'(S_CTX): return 32'hFF80_0000;
      SHW'(S_PGM): return 32'h1FFF_F800;
      SHW'(S_CAU): return 32'h08C0_0300;
      SHW'(S_CFG): return 32'h7FFF_0007;
      SHW'(S_ICT): return 32'h0000_03E0;
      SHW'(S_SRC): return 32'h0000_F3C0;
      default:     return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] vp_mask(input logic [VRW-1:0] s);
    return (s == VRW'(V_EB)) ? 32'h3FFF_F000 : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] tc_mask(input logic [TRW-1:0] s);
    case (s)
      TRW'(T_STAT): return STAT_M;
      TRW'(T_LLA):  return 32'h0;
      default:      return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] sh_rst(input int s);
    case (s)
      S_RND:   return 32'd63;
      S_PID:   return PRID_VAL;
      S_CFG:   return CFG_VAL;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] vp_rst(input int s, input int v);
    return (s == V_EB) ? (32'h8000_0000 | 32'(v)) : 32'h0;
  endfunction

  function automatic logic [31:0] tc_rst(input int s, input int t);
    case (s)
      T_STAT:  return 32'h0040_0004;
      T_TST:   return (t == 0) ? 32'h0000_8000 : 32'h0020_0000;
      T_BIND:  return 32'(t) << 21;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] n, input logic [31:0] o,
                                        input logic [31:0] m);
    return (n & m) | (o & ~m);
  endfunction

  logic [31:0] sh_q [NSH];
  logic [31:0] vp_q [NVR][NUM_VPE];
  logic [31:0] tc_q [NTR][NUM_TC];
  logic [VW-1:0] bind_vpe [NUM_TC];
  logic [5:0] rd_d, wr_d, dw_d;
  logic [VW-1:0] rd_v, wr_v, dw_v;
  logic upd_q;

  for (genvar t = 0; t < NUM_TC; t++) begin : g_bind
    assign bind_vpe[t] = (NUM_VPE == 1) ? '0 : tc_q[T_BIND][t][VW-1:0];
  end

  assign rd_d = decode(rd_idx);
  assign wr_d = decode(wr_idx);
  assign dw_d = decode(dw_idx);
  assign rd_v = bind_vpe[rd_tid];
  assign wr_v = bind_vpe[wr_tid];
  assign dw_v = bind_vpe[dw_tid];
  assign upd_pulse = upd_q;

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (rd_d[5:4])
      C_SH:    rd_data = sh_q[rd_d[SHW-1:0]];
      C_VP:    rd_data = vp_q[rd_d[VRW-1:0]][rd_v];
      C_TC:    rd_data = tc_q[rd_d[TRW-1:0]][rd_tid];
      default: rd_hit  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSH; s++) sh_q[s] <= sh_rst(s);
      for (int s = 0; s < NVR; s++)
        for (int v = 0; v < NUM_VPE; v++) vp_q[s][v] <= vp_rst(s, v);
      for (int s = 0; s < NTR; s++)
        for (int t = 0; t < NUM_TC; t++) tc_q[s][t] <= tc_rst(s, t);
    end else begin
      if (wr_en) begin
        case (wr_d[5:4])
          C_SH: sh_q[wr_d[SHW-1:0]] <= merge(wr_data, sh_q[wr_d[SHW-1:0]],
                                             sh_mask(wr_d[SHW-1:0]));
          C_VP: vp_q[wr_d[VRW-1:0]][wr_v] <= merge(wr_data, vp_q[wr_d[VRW-1:0]][wr_v],
                                                   vp_mask(wr_d[VRW-1:0]));
          C_TC: tc_q[wr_d[TRW-1:0]][wr_tid] <= merge(wr_data, tc_q[wr_d[TRW-1:0]][wr_tid],
                                                     tc_mask(wr_d[TRW-1:0]));
          default: ;
        endcase
      end
      if (dw_en) begin
        case (dw_d[5:4])
          C_SH:    sh_q[dw_d[SHW-1:0]] <= dw_data;
          C_VP:    vp_q[dw_d[VRW-1:0]][dw_v] <= dw_data;
          C_TC:    tc_q[dw_d[TRW-1:0]][dw_tid] <= dw_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= wr_en && (wr_d[5:4] != C_NONE);
  end

  // R8
  rnd_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw_en && dw_d == {C_SH, 4'(S_RND)}) |=> sh_q[S_RND] == $past(sh_q[S_RND]));

  // R3
  stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw_en && dw_d == {C_TC, 4'(T_STAT)} && dw_tid == '0)
    |=> ((tc_q[T_STAT][0] ^ $past(tc_q[T_STAT][0])) & ~STAT_M) == 32'h0);

  // R9
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !upd_pulse);

  // R9
  pulse_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_d[5:4] != C_NONE) |=> upd_pulse);

  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == 32'h0);

endmodule

// File: tb/ctl_regbank_tb.sv
module ctl_regbank_tb;
  localparam int PERIOD = 10;
  localparam logic [7:0] A_IDX = 8'h00, A_RND = 8'h08, A_CTX = 8'h20, A_BVA = 8'h40;
  localparam logic [7:0] A_ICT = 8'h61, A_CAU = 8'h68, A_PID = 8'h78, A_CFG = 8'h80;
  localparam logic [7:0] A_VCT = 8'h09, A_EB = 8'h79;
  localparam logic [7:0] A_ST = 8'h60, A_TS = 8'h11, A_TB = 8'h12, A_LLA = 8'h88;

  logic clk = 0, rst_n = 0;
  logic [1:0] rd_tid = 0, wr_tid = 0, dw_tid = 0;
  logic [7:0] rd_idx = 0, wr_idx = 0, dw_idx = 0;
  logic [31:0] wr_data = 0, dw_data = 0, rd_data;
  logic wr_en = 0, dw_en = 0, rd_hit, upd_pulse;
  int total = 0, bad = 0;
  bit done = 0;

  ctl_regbank u_dut (.clk, .rst_n, .rd_tid, .rd_idx, .rd_data, .rd_hit,
    .wr_en, .wr_tid, .wr_idx, .wr_data, .dw_en, .dw_tid, .dw_idx, .dw_data, .upd_pulse);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] t, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_tid = t; rd_idx = a;
    #1 d = rd_data;
  endtask

  task automatic mw(input logic [1:0] t, input logic [7:0] a, input logic [31:0] d,
                    output logic p);
    @(negedge clk);
    wr_en = 1; wr_tid = t; wr_idx = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; p = upd_pulse;
  endtask

  task automatic dw(input logic [1:0] t, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    dw_en = 1; dw_tid = t; dw_idx = a; dw_data = d;
    @(posedge clk); #1;
    dw_en = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int t = 0; t < 4; t++) begin
      rd(2'(t), A_ST, v); chk("R7 stat", v, 32'h0040_0004);
      rd(2'(t), A_TB, v); chk("R7 tbind", v, 32'(t) << 21);
    end
    rd(0, A_TS, v); chk("R7 tstat t0", v, 32'h0000_8000);
    rd(3, A_TS, v); chk("R7 tstat t3", v, 32'h0020_0000);
    rd(0, A_RND, v); chk("R1 rnd reset", v, 32'd63);
    rd(0, A_PID, v); chk("R1 prid reset", v, 32'h0001_9300);
    rd(1, A_EB, v);  chk("R1 exbase reset", v, 32'h8000_0000);
    chk("R9 pulse after reset", 32'(upd_pulse), 0);
  endtask

  task automatic t_mask;
    logic [31:0] v; logic p;
    mw(0, A_IDX, 32'hFFFF_FFFF, p); rd(0, A_IDX, v); chk("R3 idx", v, 32'h7FFF_FFFF);
    mw(0, A_CAU, 32'hFFFF_FFFF, p); rd(0, A_CAU, v); chk("R3 cause", v, 32'h08C0_0300);
    mw(0, A_ICT, 32'hFFFF_FFFF, p); rd(0, A_ICT, v); chk("R3 intc", v, 32'h0000_03E0);
    mw(0, A_CFG, 32'h0, p); rd(0, A_CFG, v); chk("R3 cfg keep", v, 32'h8000_0480);
    dw(0, A_CTX, 32'h1234_5678);
    mw(0, A_CTX, 32'h0, p); rd(0, A_CTX, v); chk("R3 R4 ctxt", v, 32'h0034_5678);
    mw(0, A_ST, 32'hFFFF_FFFF, p); rd(0, A_ST, v); chk("R3 stat t0", v, 32'hFF78_FF17);
    rd(1, A_ST, v); chk("R5 stat t1 untouched", v, 32'h0040_0004);
    mw(0, A_EB, 32'hFFFF_FFFF, p); rd(0, A_EB, v); chk("R3 exbase", v, 32'hBFFF_F000);
  endtask

  task automatic t_ro;
    logic [31:0] v; logic p;
    mw(0, A_RND, 32'h0, p); rd(0, A_RND, v); chk("R8 rnd", v, 32'd63);
    mw(0, A_PID, 32'hFFFF_FFFF, p); rd(0, A_PID, v); chk("R8 prid", v, 32'h0001_9300);
    mw(1, A_LLA, 32'hFFFF_FFFF, p); rd(1, A_LLA, v); chk("R8 lladr", v, 32'h0);
    dw(0, A_BVA, 32'hCAFE_0000);
    mw(0, A_BVA, 32'h1, p); rd(0, A_BVA, v); chk("R8 R4 badva", v, 32'hCAFE_0000);
    dw(2, A_LLA, 32'h0000_0ABC); rd(2, A_LLA, v); chk("R4 lladr direct", v, 32'h0000_0ABC);
  endtask

  task automatic t_unmapped;
    logic [31:0] v; logic p;
    mw(0, 8'hFF, 32'hFFFF_FFFF, p);
    chk("R9 no pulse on miss", 32'(p), 0);
    rd(0, 8'hFF, v); chk("R2 miss data", v, 0);
    chk("R2 miss hit", 32'(rd_hit), 0);
    rd(0, A_IDX, v); chk("R2 idx kept", v, 32'h7FFF_FFFF);
  endtask

  task automatic t_vpe;
    logic [31:0] v; logic p;
    mw(1, A_VCT, 32'hAAAA_0001, p);
    dw(1, A_TB, 32'h0020_0001);
    rd(1, A_VCT, v); chk("R6 vpe1 vctl", v, 32'h0);
    rd(0, A_VCT, v); chk("R6 vpe0 vctl", v, 32'hAAAA_0001);
    rd(1, A_EB, v);  chk("R6 vpe1 exbase", v, 32'h8000_0001);
    mw(1, A_VCT, 32'h0000_0055, p);
    rd(1, A_VCT, v); chk("R6 vpe1 write", v, 32'h0000_0055);
    rd(2, A_VCT, v); chk("R6 vpe0 kept", v, 32'hAAAA_0001);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1; wr_tid = 0; wr_idx = A_IDX; wr_data = 32'h0000_1111;
    dw_en = 1; dw_tid = 0; dw_idx = A_IDX; dw_data = 32'h0000_2222;
    @(posedge clk); #1;
    wr_en = 0; dw_en = 0;
    chk("R9 pulse on collide", 32'(upd_pulse), 1);
    rd(0, A_IDX, v); chk("R4 direct wins", v, 32'h0000_2222);
  endtask

  task automatic t_pulse;
    logic p;
    @(negedge clk);
    rd_tid = 3; rd_idx = A_TS;
    wr_en = 1; wr_tid = 3; wr_idx = A_TS; wr_data = 32'h0000_0F0F;
    @(posedge clk); #1;
    wr_en = 0;
    chk("R10 comb read", rd_data, 32'h0000_0F0F);
    chk("R9 pulse high", 32'(upd_pulse), 1);
    @(posedge clk); #1;
    chk("R9 pulse one cycle", 32'(upd_pulse), 0);
    mw(2, A_ST, 32'h0, p);
    chk("R9 pulse per write", 32'(p), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_mask;
    t_ro;
    t_unmapped;
    t_vpe;
    t_collide;
    t_pulse;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule